// File: doc/BRIEF.md
# Outstanding Bus Request Tracker

This block keeps one controller's copy of the table of requests outstanding on a split-transaction bus. The bus gives each request a tag when it wins arbitration. Every controller files the request at the index named by that tag, so all copies stay identical. An entry holds the block address, the request kind, and the snoop result this cache produced during the request phase. The entry is released when a response carrying the same tag appears on the response bus. The stored snoop result is presented at that moment.

Addresses are compared at block granularity against every entry at once, from two sides:

- **Processor side.** The comparison tells the processor-side controller whether a new request may go out, must wait and retry, or should take the data of an earlier read to the same block. In the last case the entry is marked, and this cache later drives the shared line so that every reader fills the line in shared state.
- **Bus side.** The comparison flags matches for each observed request. A request from this controller that meets a pending entry for the same block is withdrawn. Write-backs, upgrades and rejected requests never occupy an entry.

Top module: `reqTable`

## Requirements
- R1: After reset the table is empty: any processor request gets the issue decision, and a response produces rspHit, rspShared, rspDirty and rspToProc all 0.
- R2: An observed request of kind read (reqKind 0) or read-exclusive (reqKind 1) that is not rejected and not withdrawn fills the entry at reqTag. The entry holds the block address, the kind, reqShared, reqDirty and reqLocal (own bit), and becomes visible from the next cycle.
- R3: Upgrades (reqKind 2) and write-backs (reqKind 3) never fill an entry, so later lookups of their block miss.
- R4: Lookups compare only address bits ADDR_W-1 down to OFF_W, against all valid entries at once. busHit is 1 when reqValid is set and reqAddr's block is pending.
- R5: A response (rspValid, rspTag) frees that entry from the next cycle. A request filling the same tag in the same cycle takes precedence over the release.
- R6: With procValid set, exactly one of procIssue, procWait and procGrab is 1:
  - procIssue when no entry matches procAddr's block;
  - procGrab, with procGrabTag set to the entry's tag, when procKind is read and the matching entry is a read;
  - procWait otherwise.
- R7: A grab decision sets the entry's grab bit. The response for that entry then gives rspShared 1 and rspToProc 1.
- R8: A non-rejected request with reqLocal set whose block matches a pending entry raises withdraw in that cycle and is not filed.
- R9: A request with reqNack set is never filed.
- R10: On a response to a valid entry, rspHit is 1:
  - rspShared is the stored shared bit ORed with the grab bit;
  - rspDirty is the stored dirty bit;
  - rspToProc is the own bit ORed with the grab bit.
  
  A response to an empty entry gives all four 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | A request is on the request bus this cycle |
| reqNack | input | 1 | The request is rejected |
| reqLocal | input | 1 | The request was issued by this controller |
| reqTag | input | 3 | Tag assigned to the request |
| reqKind | input | 2 | 0 read, 1 read-exclusive, 2 upgrade, 3 write-back |
| reqAddr | input | ADDR_W | Request address |
| reqShared | input | 1 | This cache's shared snoop result for the request |
| reqDirty | input | 1 | This cache's dirty snoop result for the request |
| rspValid | input | 1 | A response is on the response bus |
| rspTag | input | 3 | Tag carried by the response |
| procValid | input | 1 | Processor side wants to issue a request |
| procKind | input | 2 | Kind of the processor request (same coding) |
| procAddr | input | ADDR_W | Processor request address |
| procIssue | output | 1 | Request may be issued |
| procWait | output | 1 | Conflicting entry pending, retry later |
| procGrab | output | 1 | Take the data of an earlier read |
| procGrabTag | output | 3 | Tag of the entry to grab, 0 otherwise |
| busHit | output | 1 | Observed request's block is pending |
| withdraw | output | 1 | Own request downgraded to no action |
| rspHit | output | 1 | Response matches a valid entry |
| rspShared | output | 1 | Shared line value to present with the response |
| rspDirty | output | 1 | Dirty line value to present with the response |
| rspToProc | output | 1 | Response data goes to the processor side |

## Verification
The lookup and decision outputs are combinational on the current table. These are procIssue, procWait, procGrab, procGrabTag, busHit, withdraw and the four response outputs. They are due in the same cycle the inputs are driven. Any fill, release or grab mark shows only after the next rising edge.

The bench drives inputs just after the falling edge and compares every output against its reference model one nanosecond later, before the rising edge. It advances the model's table at the rising edge, so each effect of a stimulus is checked in the following cycle.

// File: rtl/rtPkg.sv
package rtPkg;
  parameter int TBL_TAG_W = 3;
  localparam int TBL_DEPTH = 1 << TBL_TAG_W;

  typedef enum logic [1:0] {
    REQ_RD  = 2'd0,
    REQ_RDX = 2'd1,
    REQ_UPG = 2'd2,
    REQ_WB  = 2'd3
  } reqKind_t;

  typedef struct packed {
    logic                 alloc;
    logic [TBL_TAG_W-1:0] allocTag;
    logic                 free;
    logic [TBL_TAG_W-1:0] freeTag;
    logic                 grabSet;
    logic [TBL_TAG_W-1:0] grabTag;
  } tblStrobe_t;
endpackage

// File: rtl/rtData.sv
module rtData
  import rtPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tblStrobe_t           strobe,
  input  logic [ADDR_W-1:0]    allocAddr,
  input  reqKind_t             allocKind,
  input  logic                 allocShared,
  input  logic                 allocDirty,
  input  logic                 allocOwn,
  input  logic [ADDR_W-1:0]    procAddr,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [TBL_TAG_W-1:0] rspTag,
  output logic [TBL_DEPTH-1:0] procMatch,
  output logic [TBL_DEPTH-1:0] busMatch,
  output logic [TBL_DEPTH-1:0] entIsRd,
  output logic                 entValidAtRsp,
  output logic                 entSharedAtRsp,
  output logic                 entDirtyAtRsp,
  output logic                 entOwnAtRsp,
  output logic                 entGrabAtRsp
);
  localparam int BLK_W = ADDR_W - OFF_W;

  logic [TBL_DEPTH-1:0] entValid, entShared, entDirty, entOwn, entGrab;
  logic [BLK_W-1:0]     entBlk  [TBL_DEPTH];
  reqKind_t             entKind [TBL_DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid  <= '0;
      entShared <= '0;
      entDirty  <= '0;
      entOwn    <= '0;
      entGrab   <= '0;
      for (int i = 0; i < TBL_DEPTH; i++) begin
        entBlk[i]  <= '0;
        entKind[i] <= REQ_RD;
      end
    end else begin
      for (int i = 0; i < TBL_DEPTH; i++) begin
        if (strobe.free && strobe.freeTag == TBL_TAG_W'(i)) entValid[i] <= 1'b0;
        if (strobe.grabSet && strobe.grabTag == TBL_TAG_W'(i)) entGrab[i] <= 1'b1;
        if (strobe.alloc && strobe.allocTag == TBL_TAG_W'(i)) begin
          entValid[i]  <= 1'b1;
          entBlk[i]    <= allocAddr[ADDR_W-1:OFF_W];
          entKind[i]   <= allocKind;
          entShared[i] <= allocShared;
          entDirty[i]  <= allocDirty;
          entOwn[i]    <= allocOwn;
          entGrab[i]   <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < TBL_DEPTH; i++) begin
      procMatch[i] = entValid[i] && (entBlk[i] == procAddr[ADDR_W-1:OFF_W]);
      busMatch[i]  = entValid[i] && (entBlk[i] == busAddr[ADDR_W-1:OFF_W]);
      entIsRd[i]   = (entKind[i] == REQ_RD);
    end
  end

  assign entValidAtRsp  = entValid[rspTag];
  assign entSharedAtRsp = entShared[rspTag];
  assign entDirtyAtRsp  = entDirty[rspTag];
  assign entOwnAtRsp    = entOwn[rspTag];
  assign entGrabAtRsp   = entGrab[rspTag];

  AST_ALLOC_FILLS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.alloc |=> entValid[$past(strobe.allocTag)]);  // R2
  AST_RSP_FREES: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.free && !(strobe.alloc && strobe.allocTag == strobe.freeTag))
      |=> !entValid[$past(strobe.freeTag)]);  // R5
  AST_NO_DATALESS_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.alloc |-> (allocKind == REQ_RD || allocKind == REQ_RDX));  // R3
  AST_GRAB_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    strobe.grabSet |-> (entValid[strobe.grabTag] && entKind[strobe.grabTag] == REQ_RD));  // R7
  AST_ONE_PER_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    $countones(busMatch) <= 1);  // R4
endmodule

// File: rtl/rtCtrl.sv
module rtCtrl
  import rtPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqNack,
  input  logic                 reqLocal,
  input  logic [TBL_TAG_W-1:0] reqTag,
  input  reqKind_t             reqKind,
  input  logic                 rspValid,
  input  logic [TBL_TAG_W-1:0] rspTag,
  input  logic                 procValid,
  input  reqKind_t             procKind,
  input  logic [TBL_DEPTH-1:0] procMatch,
  input  logic [TBL_DEPTH-1:0] busMatch,
  input  logic [TBL_DEPTH-1:0] entIsRd,
  output tblStrobe_t           strobe,
  output logic                 procIssue,
  output logic                 procWait,
  output logic                 procGrab,
  output logic [TBL_TAG_W-1:0] procGrabTag,
  output logic                 busHit,
  output logic                 withdraw
);
  logic                 procHitAny;
  logic [TBL_TAG_W-1:0] procIdx;
  logic                 hasResponse;

  always_comb begin
    procIdx = '0;
    for (int i = TBL_DEPTH - 1; i >= 0; i--)
      if (procMatch[i]) procIdx = TBL_TAG_W'(i);
  end

  assign procHitAny  = |procMatch;
  assign procGrab    = procValid && procHitAny && procKind == REQ_RD && entIsRd[procIdx];
  assign procWait    = procValid && procHitAny && !procGrab;
  assign procIssue   = procValid && !procHitAny;
  assign procGrabTag = procGrab ? procIdx : '0;

  assign busHit      = reqValid && (|busMatch);
  assign withdraw    = reqValid && !reqNack && reqLocal && busHit;
  assign hasResponse = (reqKind == REQ_RD) || (reqKind == REQ_RDX);

  always_comb begin
    strobe          = '0;
    strobe.alloc    = reqValid && !reqNack && !withdraw && hasResponse;
    strobe.allocTag = reqTag;
    strobe.free     = rspValid;
    strobe.freeTag  = rspTag;
    strobe.grabSet  = procGrab;
    strobe.grabTag  = procIdx;
  end

  AST_ONE_DECISION: assert property (@(posedge clk) disable iff (!rstN)
    procValid |-> $onehot({procIssue, procWait, procGrab}));  // R6
endmodule

// File: rtl/reqTable.sv
module reqTable
  import rtPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqNack,
  input  logic                 reqLocal,
  input  logic [TBL_TAG_W-1:0] reqTag,
  input  logic [1:0]           reqKind,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic                 reqShared,
  input  logic                 reqDirty,
  input  logic                 rspValid,
  input  logic [TBL_TAG_W-1:0] rspTag,
  input  logic                 procValid,
  input  logic [1:0]           procKind,
  input  logic [ADDR_W-1:0]    procAddr,
  output logic                 procIssue,
  output logic                 procWait,
  output logic                 procGrab,
  output logic [TBL_TAG_W-1:0] procGrabTag,
  output logic                 busHit,
  output logic                 withdraw,
  output logic                 rspHit,
  output logic                 rspShared,
  output logic                 rspDirty,
  output logic                 rspToProc
);
  tblStrobe_t           strobe;
  logic [TBL_DEPTH-1:0] procMatch, busMatch, entIsRd;
  logic                 eValid, eShared, eDirty, eOwn, eGrab;

  rtCtrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqNack(reqNack), .reqLocal(reqLocal),
    .reqTag(reqTag), .reqKind(reqKind_t'(reqKind)),
    .rspValid(rspValid), .rspTag(rspTag),
    .procValid(procValid), .procKind(reqKind_t'(procKind)),
    .procMatch(procMatch), .busMatch(busMatch), .entIsRd(entIsRd),
    .strobe(strobe),
    .procIssue(procIssue), .procWait(procWait), .procGrab(procGrab),
    .procGrabTag(procGrabTag), .busHit(busHit), .withdraw(withdraw)
  );

  rtData #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .allocAddr(reqAddr), .allocKind(reqKind_t'(reqKind)),
    .allocShared(reqShared), .allocDirty(reqDirty), .allocOwn(reqLocal),
    .procAddr(procAddr), .busAddr(reqAddr), .rspTag(rspTag),
    .procMatch(procMatch), .busMatch(busMatch), .entIsRd(entIsRd),
    .entValidAtRsp(eValid), .entSharedAtRsp(eShared), .entDirtyAtRsp(eDirty),
    .entOwnAtRsp(eOwn), .entGrabAtRsp(eGrab)
  );

  assign rspHit    = rspValid && eValid;
  assign rspShared = rspHit && (eShared || eGrab);
  assign rspDirty  = rspHit && eDirty;
  assign rspToProc = rspHit && (eOwn || eGrab);
endmodule

// File: tb/reqTable_tb.sv
module reqTable_tb;
  localparam int AW = 32;
  localparam int OW = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid, reqNack, reqLocal, reqShared, reqDirty, rspValid, procValid;
  logic [2:0] reqTag, rspTag, procGrabTag;
  logic [1:0] reqKind, procKind;
  logic [AW-1:0] reqAddr, procAddr;
  logic procIssue, procWait, procGrab, busHit, withdraw;
  logic rspHit, rspShared, rspDirty, rspToProc;

  int checks = 0;
  int errors = 0;

  // reference table
  bit        mValid [8];
  bit [AW-1:0] mBlk [8];
  int        mKind  [8];
  bit        mSh [8], mDt [8], mOwn [8], mGrab [8];

  always #4 clk = ~clk;

  reqTable u_dut (.*);

  task automatic chk(string tag, string what, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic idle();
    reqValid = 0; reqNack = 0; reqLocal = 0; reqTag = 0; reqKind = 0;
    reqAddr = 0; reqShared = 0; reqDirty = 0;
    rspValid = 0; rspTag = 0; procValid = 0; procKind = 0; procAddr = 0;
  endtask

  function automatic int findBlk(logic [AW-1:0] a);
    for (int i = 0; i < 8; i++)
      if (mValid[i] && mBlk[i] == (a >> OW)) return i;
    return -1;
  endfunction

  // compare all outputs now, then advance the model at the rising edge
  task automatic cycle(string tag);
    int pi, bi;
    bit eGrab, eWait, eIssue, eBus, eWd, eHit, alloc;
    #1;
    pi = findBlk(procAddr);
    bi = findBlk(reqAddr);
    eGrab  = procValid && pi >= 0 && procKind == 0 && mKind[pi] == 0;
    eWait  = procValid && pi >= 0 && !eGrab;
    eIssue = procValid && pi < 0;
    eBus   = reqValid && bi >= 0;
    eWd    = reqValid && !reqNack && reqLocal && eBus;
    eHit   = rspValid && mValid[rspTag];
    chk(tag, "procIssue R6", {7'd0, procIssue}, {7'd0, eIssue});
    chk(tag, "procWait R6", {7'd0, procWait}, {7'd0, eWait});
    chk(tag, "procGrab R6", {7'd0, procGrab}, {7'd0, eGrab});
    chk(tag, "procGrabTag R6", {5'd0, procGrabTag}, eGrab ? 8'(pi) : 8'd0);
    chk(tag, "busHit R4", {7'd0, busHit}, {7'd0, eBus});
    chk(tag, "withdraw R8", {7'd0, withdraw}, {7'd0, eWd});
    chk(tag, "rspHit R10", {7'd0, rspHit}, {7'd0, eHit});
    chk(tag, "rspShared R7", {7'd0, rspShared}, {7'd0, eHit && (mSh[rspTag] || mGrab[rspTag])});
    chk(tag, "rspDirty R10", {7'd0, rspDirty}, {7'd0, eHit && mDt[rspTag]});
    chk(tag, "rspToProc R10", {7'd0, rspToProc}, {7'd0, eHit && (mOwn[rspTag] || mGrab[rspTag])});
    alloc = reqValid && !reqNack && !eWd && reqKind < 2;
    @(posedge clk);
    if (rspValid) mValid[rspTag] = 0;
    if (eGrab) mGrab[pi] = 1;
    if (alloc) begin
      mValid[reqTag] = 1; mBlk[reqTag] = reqAddr >> OW; mKind[reqTag] = reqKind;
      mSh[reqTag] = reqShared; mDt[reqTag] = reqDirty; mOwn[reqTag] = reqLocal;
      mGrab[reqTag] = 0;
    end
    @(negedge clk);
  endtask

  task automatic bus(bit local_, bit nack, logic [2:0] tag, logic [1:0] kind,
                     logic [AW-1:0] a, bit sh, bit dt);
    reqValid = 1; reqLocal = local_; reqNack = nack; reqTag = tag; reqKind = kind;
    reqAddr = a; reqShared = sh; reqDirty = dt;
  endtask

  task automatic proc(logic [1:0] kind, logic [AW-1:0] a);
    procValid = 1; procKind = kind; procAddr = a;
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    for (int i = 0; i < 8; i++) mValid[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state, issue everywhere, empty response
    proc(0, 32'h1000); rspValid = 1; rspTag = 3; cycle("R1");
    rstN = 1; @(negedge clk);
    idle(); proc(1, 32'h7000); rspValid = 1; rspTag = 0; cycle("R1");
    // R2: local read to A at tag 2
    idle(); bus(1, 0, 2, 0, 32'h1000, 0, 0); cycle("R2");
    // R6/R7: read to A grabs tag 2
    idle(); proc(0, 32'h1010); cycle("R6");
    // R2: remote read-exclusive to B at tag 5, dirty
    idle(); bus(0, 0, 5, 1, 32'h2000, 0, 1); cycle("R2");
    idle(); proc(0, 32'h2000); cycle("R6");
    // R4: same block, different offset -> wait; other block -> issue
    idle(); proc(1, 32'h2044); cycle("R4");
    idle(); proc(0, 32'h2080); bus(0, 0, 7, 0, 32'h20FC, 0, 0); cycle("R4");
    // R3: write-back and upgrade not filed
    idle(); bus(0, 0, 1, 3, 32'h3000, 0, 0); cycle("R3");
    idle(); bus(0, 0, 3, 2, 32'h3000, 0, 0); proc(0, 32'h3000); cycle("R3");
    idle(); proc(1, 32'h3000); rspValid = 1; rspTag = 1; cycle("R3");
    // R9: rejected read not filed
    idle(); bus(0, 1, 4, 0, 32'h4000, 1, 1); cycle("R9");
    idle(); proc(0, 32'h4000); rspValid = 1; rspTag = 4; cycle("R9");
    // R8: own read-exclusive to pending block B withdrawn
    idle(); bus(1, 0, 6, 1, 32'h2000, 0, 0); cycle("R8");
    idle(); rspValid = 1; rspTag = 6; cycle("R8");
    // R7/R10: response for grabbed tag 2
    idle(); rspValid = 1; rspTag = 2; cycle("R7");
    // R5: A free again
    idle(); proc(1, 32'h1000); cycle("R5");
    // R5: response frees tag 5 while a remote read refills it with E
    idle(); rspValid = 1; rspTag = 5; bus(0, 0, 5, 0, 32'h5000, 0, 0); cycle("R5");
    idle(); proc(0, 32'h2000); cycle("R5");
    idle(); proc(0, 32'h5000); cycle("R6");
    idle(); rspValid = 1; rspTag = 5; cycle("R7");
    // R10: own read, shared snoop
    idle(); bus(1, 0, 0, 0, 32'h6000, 1, 0); cycle("R2");
    idle(); rspValid = 1; rspTag = 0; cycle("R10");
    idle(); proc(0, 32'h6000); rspValid = 1; rspTag = 0; cycle("R10");
    idle(); repeat (2) cycle("R1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule